// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block sequences the strobes of one programmed-I/O access on an ATA channel with two drives. Each access runs through three phases: an address setup phase, an active phase with the read or write strobe asserted, and a recovery phase with the strobe negated. The length of each phase comes from timing bytes that the host loads through a small register-write port. Each drive has one data timing byte and one address timing byte.

A start request, the drive select and a read/write flag launch one access. The block holds the address-valid window for the whole access and pulses done on its final clock. A mode input chooses how the setup phase is sized. In per-drive mode the block takes the slower of the two drives' setup settings by itself. In shared mode the drive-0 address timing byte sizes the setup phase for both drives. That shared byte also carries a pending-interrupt flag, and a write can clear the flag.

The sequencer has four states. IDLE moves to SETUP on an accepted start. SETUP moves to ACTIVE when its count runs out. ACTIVE moves to RECOVER when its count runs out. RECOVER returns to IDLE when its count runs out.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset all strobes, address_valid, done and intr_pending are low. Both data timing bytes read as 0x3F (active 3 clocks, recovery 16 clocks) and both address timing bytes as 0x40 (setup 2 clocks).
- R2: An accepted start is sampled on a rising edge. From the next clock, address_valid stays high for exactly S+A+R clocks. The strobe is high for exactly the A clocks that follow the first S clocks.
- R3: With is_write high the strobe used is wr_stb, otherwise rd_stb. The two strobes are never high together.
- R4: Active count A is bits 7:4 of the selected drive's data timing byte, and the value 0 means 16 clocks.
- R5: Recovery count R comes from code c in bits 3:0 of that byte. Code 0 means 16 clocks and any other code means c+1 clocks, so code 15 also gives 16.
- R6: The setup field is bits 7:6 of an address timing byte: 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R7: With shared_setup low, S is the larger of the two drives' decoded setup counts, whichever drive is selected.
- R8: With shared_setup high, S comes from the drive-0 address timing byte for both drives, and the drive-1 address timing byte has no effect.
- R9: intr_set makes intr_pending high from the next clock. A write to the drive-0 address timing byte with bit 4 = 1 clears it. The same write with bit 4 = 0 leaves it unchanged. intr_set wins over a clear in the same cycle.
- R10: done is a single-clock pulse on the last recovery clock. A start that arrives while an access is running is ignored and does not queue.
- R11: A timing byte written during an access, or in the cycle its start is accepted, changes nothing until the next access.
- R12: Register addresses on cfg_addr: 0 is drive-0 data timing, 1 is drive-1 data timing, 2 is drive-0 address timing (the shared byte), 3 is drive-1 address timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one access when idle |
| drive_sel | input | 1 | Drive addressed by the access |
| is_write | input | 1 | 1 for a write access, 0 for a read |
| shared_setup | input | 1 | 1 selects shared setup mode |
| cfg_we | input | 1 | Timing byte write enable |
| cfg_addr | input | 2 | Timing byte address (R12) |
| cfg_wdata | input | 8 | Timing byte write data |
| intr_set | input | 1 | Raises the pending-interrupt flag |
| address_valid | output | 1 | High during the whole access |
| rd_stb | output | 1 | Read strobe, active phase of a read |
| wr_stb | output | 1 | Write strobe, active phase of a write |
| done | output | 1 | Pulse on the last recovery clock |
| intr_pending | output | 1 | Pending-interrupt flag |

## Verification
The assertions assume start, drive_sel, is_write and shared_setup are stable, known levels at each rising edge, and that intr_set and cfg_we are single-cycle qualified pulses. The stimulus changes every input only on falling edges. It writes each timing byte in its own cycle. It holds drive_sel and is_write steady from the start request to the end of the access. Starts during a running access are issued on purpose, to show they are dropped rather than queued.

// File: rtl/ata_tim_pkg.sv
package ata_tim_pkg;

    localparam int TIM_BYTE_W = 8;
    localparam int TIM_CNT_W  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER
    } tim_state_e;

    // nibble 0 stands for the longest strobe, 16 clocks
    function automatic logic [TIM_CNT_W-1:0] dec_active(input logic [3:0] nib);
        return (nib == 4'd0) ? TIM_CNT_W'(16) : TIM_CNT_W'(nib);
    endfunction

    // code 0 is 16 clocks, otherwise code+1 (code 15 also lands on 16)
    function automatic logic [TIM_CNT_W-1:0] dec_recovery(input logic [3:0] code);
        return (code == 4'd0) ? TIM_CNT_W'(16) : TIM_CNT_W'(code) + TIM_CNT_W'(1);
    endfunction

    function automatic logic [TIM_CNT_W-1:0] dec_setup(input logic [1:0] fld);
        logic [TIM_CNT_W-1:0] n;
        unique case (fld)
            2'b01:   n = TIM_CNT_W'(2);
            2'b10:   n = TIM_CNT_W'(3);
            2'b00:   n = TIM_CNT_W'(4);
            default: n = TIM_CNT_W'(5);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ata_tim_regs.sv
module ata_tim_regs
    import ata_tim_pkg::*;
#(
    parameter int BYTE_W = TIM_BYTE_W,
    parameter int CNT_W  = TIM_CNT_W,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              intr_set,
    input  logic              drive_sel,
    input  logic              shared_setup,
    output logic [CNT_W-1:0]  setup_cnt,
    output logic [CNT_W-1:0]  act_cnt,
    output logic [CNT_W-1:0]  rec_cnt,
    output logic              intr_pending
);

    localparam int NUM_DRV   = 2;
    localparam int FLAG_BIT  = 4;
    localparam int SET_LSB   = BYTE_W - 2;
    localparam logic [BYTE_W-1:0] DATA_RST = BYTE_W'(8'h3F);
    localparam logic [1:0]        SET_RST  = 2'b01;

    logic [BYTE_W-1:0] data_q [NUM_DRV];
    logic [1:0]        setf_q [NUM_DRV];

    genvar g;
    generate
        for (g = 0; g < NUM_DRV; g++) begin : g_drv
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    data_q[g] <= DATA_RST;
                    setf_q[g] <= SET_RST;
                end else if (cfg_we) begin
                    if (cfg_addr == ADDR_W'(g))
                        data_q[g] <= cfg_wdata;
                    if (cfg_addr == ADDR_W'(NUM_DRV + g))
                        setf_q[g] <= cfg_wdata[SET_LSB +: 2];
                end
            end
        end
    endgenerate

    logic clr_hit;
    assign clr_hit = cfg_we && (cfg_addr == ADDR_W'(NUM_DRV)) && cfg_wdata[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n)        intr_pending <= 1'b0;
        else if (intr_set) intr_pending <= 1'b1;
        else if (clr_hit)  intr_pending <= 1'b0;
    end

    logic [CNT_W-1:0] s0, s1;
    logic [BYTE_W-1:0] sel_data;

    always_comb begin
        s0       = CNT_W'(dec_setup(setf_q[0]));
        s1       = CNT_W'(dec_setup(setf_q[1]));
        sel_data = data_q[drive_sel];
        if (shared_setup) setup_cnt = s0;
        else              setup_cnt = (s0 > s1) ? s0 : s1;
        act_cnt  = CNT_W'(dec_active(sel_data[BYTE_W-1 -: 4]));
        rec_cnt  = CNT_W'(dec_recovery(sel_data[3:0]));
    end

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        intr_set |=> intr_pending);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(NUM_DRV) && !cfg_wdata[FLAG_BIT] && !intr_set)
        |=> (intr_pending == $past(intr_pending)));

    p_setup_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_cnt >= CNT_W'(2)) && (setup_cnt <= CNT_W'(5)));

endmodule

// File: rtl/ata_tim_seq.sv
module ata_tim_seq
    import ata_tim_pkg::*;
#(
    parameter int CNT_W = TIM_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] act_cnt,
    input  logic [CNT_W-1:0] rec_cnt,
    output logic             address_valid,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             done
);

    tim_state_e       state_q;
    logic [CNT_W-1:0] cnt_q, act_q, rec_q;
    logic             wr_q;
    logic             last;

    assign last = (cnt_q == '0);

    // state register and phase counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            act_q   <= '0;
            rec_q   <= '0;
            wr_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_SETUP;
                    cnt_q   <= setup_cnt - CNT_W'(1);
                    act_q   <= act_cnt;
                    rec_q   <= rec_cnt;
                    wr_q    <= is_write;
                end
                ST_SETUP: if (last) begin
                    state_q <= ST_ACTIVE;
                    cnt_q   <= act_q - CNT_W'(1);
                end else cnt_q <= cnt_q - CNT_W'(1);
                ST_ACTIVE: if (last) begin
                    state_q <= ST_RECOVER;
                    cnt_q   <= rec_q - CNT_W'(1);
                end else cnt_q <= cnt_q - CNT_W'(1);
                ST_RECOVER: if (last) state_q <= ST_IDLE;
                            else      cnt_q   <= cnt_q - CNT_W'(1);
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        address_valid = 1'b0;
        rd_stb        = 1'b0;
        wr_stb        = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SETUP:   address_valid = 1'b1;
            ST_ACTIVE: begin
                address_valid = 1'b1;
                rd_stb        = !wr_q;
                wr_stb        = wr_q;
            end
            ST_RECOVER: begin
                address_valid = 1'b1;
                done          = last;
            end
            default: ;
        endcase
    end

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

    p_strobe_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb) |-> address_valid);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !address_valid));

    p_latch_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
        |-> ($stable(act_q) && $stable(rec_q) && $stable(wr_q)));

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
    import ata_tim_pkg::*;
#(
    parameter int BYTE_W = TIM_BYTE_W,
    parameter int CNT_W  = TIM_CNT_W,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              drive_sel,
    input  logic              is_write,
    input  logic              shared_setup,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              intr_set,
    output logic              address_valid,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              done,
    output logic              intr_pending
);

    logic [CNT_W-1:0] setup_cnt, act_cnt, rec_cnt;

    ata_tim_regs #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .intr_set     (intr_set),
        .drive_sel    (drive_sel),
        .shared_setup (shared_setup),
        .setup_cnt    (setup_cnt),
        .act_cnt      (act_cnt),
        .rec_cnt      (rec_cnt),
        .intr_pending (intr_pending)
    );

    ata_tim_seq #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .is_write      (is_write),
        .setup_cnt     (setup_cnt),
        .act_cnt       (act_cnt),
        .rec_cnt       (rec_cnt),
        .address_valid (address_valid),
        .rd_stb        (rd_stb),
        .wr_stb        (wr_stb),
        .done          (done)
    );

endmodule

// File: tb/tb_ata_pio_timer.sv
module tb_ata_pio_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, drive_sel = 1'b0, is_write = 1'b0, shared_setup = 1'b0;
    logic       cfg_we = 1'b0, intr_set = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       address_valid, rd_stb, wr_stb, done, intr_pending;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ata_pio_timer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .drive_sel(drive_sel),
        .is_write(is_write), .shared_setup(shared_setup), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .intr_set(intr_set),
        .address_valid(address_valid), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .done(done), .intr_pending(intr_pending)
    );

    typedef struct packed {
        logic [7:0] d0, d1, a0, a1;
        logic       sh, drv, wr;
        logic [4:0] es, ea, er;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h3F, 8'h3F, 8'h40, 8'h40, 1'b0, 1'b0, 1'b0, 5'd2, 5'd3,  5'd16},
        '{8'h00, 8'h3F, 8'h80, 8'h40, 1'b0, 1'b0, 1'b1, 5'd3, 5'd16, 5'd16},
        '{8'h3F, 8'h51, 8'h40, 8'hC0, 1'b0, 1'b1, 1'b0, 5'd5, 5'd5,  5'd2},
        '{8'h3F, 8'h1F, 8'h00, 8'h40, 1'b0, 1'b1, 1'b1, 5'd4, 5'd1,  5'd16},
        '{8'h2E, 8'h3F, 8'h40, 8'hC0, 1'b1, 1'b0, 1'b0, 5'd2, 5'd2,  5'd15},
        '{8'h3F, 8'hF1, 8'h80, 8'h40, 1'b1, 1'b1, 1'b1, 5'd3, 5'd15, 5'd2},
        '{8'h12, 8'h3F, 8'hC0, 8'h00, 1'b0, 1'b0, 1'b0, 5'd5, 5'd1,  5'd3},
        '{8'h3F, 8'hE9, 8'h00, 8'h80, 1'b1, 1'b1, 1'b0, 5'd4, 5'd14, 5'd10}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // runs one access and measures its phases at the ports
    task automatic run_cycle(input logic drv, input logic wr, input bit mid_wr,
                             input logic [1:0] mid_a, input logic [7:0] mid_d,
                             input bit mid_start,
                             output int s, output int a, output int r,
                             output int dn, output int dat, output int bad);
        bit seen = 1'b0;
        s = 0; a = 0; r = 0; dn = 0; dat = -1; bad = 0;
        @(negedge clk);
        drive_sel = drv; is_write = wr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 80; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 1) begin
                if (mid_wr) begin cfg_we = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d; end
                if (mid_start) start = 1'b1;
            end
            if (i == 2) begin cfg_we = 1'b0; start = 1'b0; end
            if (!address_valid) begin
                if (s > 0) break;
            end else if (rd_stb || wr_stb) begin
                a++; seen = 1'b1;
                if ((rd_stb && wr_stb) || (wr_stb != wr)) bad++;
            end else if (!seen) s++;
            else r++;
            if (done) begin dn++; dat = r; end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int s, a, r, dn, dat, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(!address_valid && !rd_stb && !wr_stb && !done, "R1 idle outputs",
              int'({address_valid, rd_stb, wr_stb, done}), 0);
        check(!intr_pending, "R1 flag", int'(intr_pending), 0);
        run_cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h0, 1'b0, s, a, r, dn, dat, bad);
        check(s == 2 && a == 3 && r == 16, "R1 reset timing", s*1000 + a*100 + r, 2*1000 + 3*100 + 16);

        // table of vectors covering R2-R8, R10, R12
        for (int v = 0; v < NV; v++) begin
            write_reg(2'd0, VECS[v].d0);
            write_reg(2'd1, VECS[v].d1);
            write_reg(2'd2, VECS[v].a0);
            write_reg(2'd3, VECS[v].a1);
            shared_setup = VECS[v].sh;
            run_cycle(VECS[v].drv, VECS[v].wr, 1'b0, 2'd0, 8'h0, 1'b0, s, a, r, dn, dat, bad);
            check(s == int'(VECS[v].es), "R6/R7/R8 setup", s, int'(VECS[v].es));
            check(a == int'(VECS[v].ea), "R4 active", a, int'(VECS[v].ea));
            check(r == int'(VECS[v].er), "R5 recovery", r, int'(VECS[v].er));
            check(bad == 0, "R3 strobe select", bad, 0);
            check(dn == 1 && dat == int'(VECS[v].er), "R10 done position", dat, int'(VECS[v].er));
        end

        // R10: start during a running access is dropped
        shared_setup = 1'b0;
        write_reg(2'd0, 8'h3F); write_reg(2'd2, 8'h40); write_reg(2'd3, 8'h40);
        run_cycle(1'b0, 1'b1, 1'b0, 2'd0, 8'h0, 1'b1, s, a, r, dn, dat, bad);
        check(s == 2 && a == 3 && r == 16, "R10 first access", s*1000 + a*100 + r, 2316);
        begin
            int hits = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (address_valid) hits++;
            end
            check(hits == 0, "R10 no queued start", hits, 0);
        end

        // R11: write during an access applies to the next one only
        run_cycle(1'b0, 1'b0, 1'b1, 2'd0, 8'h51, 1'b0, s, a, r, dn, dat, bad);
        check(a == 3 && r == 16, "R11 old timing kept", a*100 + r, 316);
        run_cycle(1'b0, 1'b0, 1'b0, 2'd0, 8'h0, 1'b0, s, a, r, dn, dat, bad);
        check(a == 5 && r == 2, "R11 new timing used", a*100 + r, 502);

        // R8: drive-1 address byte ignored in shared mode
        shared_setup = 1'b1;
        write_reg(2'd3, 8'hC0);
        run_cycle(1'b1, 1'b0, 1'b0, 2'd0, 8'h0, 1'b0, s, a, r, dn, dat, bad);
        check(s == 2, "R8 shared ignores drive1", s, 2);
        shared_setup = 1'b0;

        // R9: pending flag
        @(negedge clk); intr_set = 1'b1;
        @(negedge clk); intr_set = 1'b0;
        check(intr_pending, "R9 set", int'(intr_pending), 1);
        write_reg(2'd2, 8'h40);
        check(intr_pending, "R9 zero write keeps", int'(intr_pending), 1);
        write_reg(2'd2, 8'h50);
        check(!intr_pending, "R9 one write clears", int'(intr_pending), 0);
        @(negedge clk);
        intr_set = 1'b1; cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 8'h50;
        @(negedge clk);
        intr_set = 1'b0; cfg_we = 1'b0;
        check(intr_pending, "R9 set wins", int'(intr_pending), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule